// File: doc/BRIEF.md
# Fixed-Length Packet Field Decoder

This block sits beside a link-level packet validity checker and watches the same received symbol stream. Each symbol carries a kind (idle, start, data or end) and a data byte. When a start symbol arrives the decoder collects a fixed number of data bytes into a holding register. It then requires an end symbol in the slot that follows the last data byte. Finally it waits for the validity checker to report on that packet. The decoded fields reach the output register, together with a one-cycle valid pulse, only when the framing is correct and the checker reports the packet as good.

Rejection is the default outcome. A start symbol inside a packet discards the partial packet and begins capture again. An idle or end symbol among the payload bytes ends decoding, and so does any symbol other than end in the end slot. A packet whose type field does not match the configured type is ignored until the next start. A checker report that arrives while no framed packet is waiting has no effect. Because of these rules, random noise on a disconnected line cannot produce a decode unless the checker itself accepts the packet.

Top module: `fixlen_pkt_decoder`

## Requirements
- R1: While reset is active and after it is released, `decode_valid_o` is 0 and `fields_o` is all zeros.
- R2: A good packet produces `decode_valid_o` high for exactly one cycle. A good packet is a valid start symbol (kind 2'b01), then PAYLOAD_LEN valid data symbols (kind 2'b10), then a valid end symbol (kind 2'b11), and afterwards a cycle with `chk_done_i`=1 and `chk_err_i`=0. The pulse is in the cycle after the clock edge that samples that done. At the same edge, byte k of the payload (k=0 first) appears at `fields_o[k*DATA_W +: DATA_W]`.
- R3: If the checker's done arrives with `chk_err_i`=1, there is no pulse and `fields_o` keeps its value.
- R4: A valid start symbol received while payload bytes are being collected, or in the end slot, discards the partial packet. Capture restarts with the next data symbol as payload byte 0.
- R5: A valid symbol other than end or start in the end slot aborts the packet. A later good checker report does not produce a pulse.
- R6: A valid idle (kind 2'b00) or end symbol among the payload bytes aborts the packet. No pulse follows.
- R7: If the top TYPE_W bits of payload byte 0 differ from PKT_TYPE (default 4'hA), the packet is ignored until the next start symbol.
- R8: A cycle with `sym_valid_i`=0 has no effect, whatever kind and data are presented with it.
- R9: `fields_o` changes only at the edge that raises `decode_valid_o`, and it holds its value until the next accepted packet.
- R10: A checker done that arrives while no framed packet is waiting for status is ignored. After reset, no pulse occurs before a complete packet ending in an end symbol has been approved.
- R11: While the decoder waits for status, a valid start symbol without a done drops the waiting packet. If a done and a start symbol arrive in the same cycle, the waiting packet is judged by that done and a new capture also begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Symbol present this cycle |
| sym_kind_i | input | 2 | 00 idle, 01 start, 10 data, 11 end |
| sym_data_i | input | DATA_W | Symbol byte |
| chk_done_i | input | 1 | Checker verdict strobe |
| chk_err_i | input | 1 | Checker verdict: 1 = bad packet |
| decode_valid_o | output | 1 | One-cycle accept pulse |
| fields_o | output | DATA_W*PAYLOAD_LEN | Payload of the last accepted packet |

## Verification
Each symbol takes effect at the clock edge that samples it. The accept pulse and the new field value appear together, one edge after the checker's done is sampled, and the pulse drops again at the next edge. The bench drives inputs on the falling edge and samples both outputs 2 ns after every rising edge. At each of those samples it compares against the pulse and field value it expects, so a pulse that comes early, late or twice is reported in the cycle where it happens.

// File: rtl/fixlen_pkt_pkg.sv
package fixlen_pkt_pkg;

  typedef enum logic [1:0] {
    SYM_IDLE = 2'b00,
    SYM_SOP  = 2'b01,
    SYM_DATA = 2'b10,
    SYM_EOP  = 2'b11
  } sym_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PAYLOAD,
    ST_WAIT_EOP,
    ST_WAIT_STATUS
  } dec_state_e;

endpackage

// File: rtl/fixlen_pkt_fsm.sv
module fixlen_pkt_fsm
  import fixlen_pkt_pkg::*;
#(
  parameter int PAYLOAD_LEN = 6,
  parameter int TYPE_W      = 4,
  parameter int PKT_TYPE    = 4'hA,
  localparam int CNT_W      = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_valid_i,
  input  logic [1:0]        sym_kind_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              chk_done_i,
  input  logic              chk_err_i,
  output logic              cap_en_o,
  output logic [CNT_W-1:0]  cap_idx_o,
  output logic              accept_o
);

  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(PAYLOAD_LEN - 1);
  localparam logic [TYPE_W-1:0] WANT     = TYPE_W'(PKT_TYPE);

  dec_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  sym_kind_e        kind;
  logic             is_sop;

  assign kind   = sym_kind_e'(sym_kind_i);
  assign is_sop = sym_valid_i && (kind == SYM_SOP);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cap_en_o = 1'b0;
    accept_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (is_sop) begin
          state_d = ST_PAYLOAD;
          cnt_d   = '0;
        end
      end
      ST_PAYLOAD: begin
        if (sym_valid_i) begin
          unique case (kind)
            SYM_SOP: cnt_d = '0;
            SYM_DATA: begin
              if (cnt_q == '0 && type_i != WANT) begin
                state_d = ST_IDLE;
              end else begin
                cap_en_o = 1'b1;
                if (cnt_q == LAST_IDX) begin
                  state_d = ST_WAIT_EOP;
                  cnt_d   = '0;
                end else begin
                  cnt_d = cnt_q + 1'b1;
                end
              end
            end
            default: state_d = ST_IDLE;  // idle gap or early end
          endcase
        end
      end
      ST_WAIT_EOP: begin
        if (sym_valid_i) begin
          if (kind == SYM_EOP) begin
            state_d = ST_WAIT_STATUS;
          end else if (kind == SYM_SOP) begin
            state_d = ST_PAYLOAD;
            cnt_d   = '0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_WAIT_STATUS: begin
        // verdict for the waiting packet wins; a coincident start still opens capture
        if (chk_done_i) begin
          accept_o = !chk_err_i;
          state_d  = is_sop ? ST_PAYLOAD : ST_IDLE;
          cnt_d    = '0;
        end else if (is_sop) begin
          state_d = ST_PAYLOAD;
          cnt_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cap_idx_o = cnt_q;

endmodule

// File: rtl/fixlen_pkt_capture.sv
module fixlen_pkt_capture #(
  parameter int DATA_W      = 8,
  parameter int PAYLOAD_LEN = 6,
  localparam int CNT_W      = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1,
  localparam int FIELDS_W   = DATA_W * PAYLOAD_LEN
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                cap_en_i,
  input  logic [CNT_W-1:0]    cap_idx_i,
  input  logic                accept_i,
  output logic                valid_o,
  output logic [FIELDS_W-1:0] fields_o
);

  logic [FIELDS_W-1:0] shadow_q;

  for (genvar i = 0; i < PAYLOAD_LEN; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[i*DATA_W +: DATA_W] <= '0;
      end else if (cap_en_i && cap_idx_i == CNT_W'(i)) begin
        shadow_q[i*DATA_W +: DATA_W] <= data_i;
      end
    end
  end

  // separate output copy keeps fields stable while the next packet fills the shadow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= accept_i;
      if (accept_i) fields_o <= shadow_q;
    end
  end

endmodule

// File: rtl/fixlen_pkt_decoder.sv
module fixlen_pkt_decoder #(
  parameter int DATA_W      = 8,
  parameter int PAYLOAD_LEN = 6,
  parameter int TYPE_W      = 4,
  parameter int PKT_TYPE    = 4'hA
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sym_valid_i,
  input  logic [1:0]                    sym_kind_i,
  input  logic [DATA_W-1:0]             sym_data_i,
  input  logic                          chk_done_i,
  input  logic                          chk_err_i,
  output logic                          decode_valid_o,
  output logic [DATA_W*PAYLOAD_LEN-1:0] fields_o
);

  localparam int CNT_W = (PAYLOAD_LEN > 1) ? $clog2(PAYLOAD_LEN) : 1;

  logic             cap_en;
  logic [CNT_W-1:0] cap_idx;
  logic             accept;

  fixlen_pkt_fsm #(
    .PAYLOAD_LEN (PAYLOAD_LEN),
    .TYPE_W      (TYPE_W),
    .PKT_TYPE    (PKT_TYPE)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_valid_i (sym_valid_i),
    .sym_kind_i  (sym_kind_i),
    .type_i      (sym_data_i[DATA_W-1 -: TYPE_W]),
    .chk_done_i  (chk_done_i),
    .chk_err_i   (chk_err_i),
    .cap_en_o    (cap_en),
    .cap_idx_o   (cap_idx),
    .accept_o    (accept)
  );

  fixlen_pkt_capture #(
    .DATA_W      (DATA_W),
    .PAYLOAD_LEN (PAYLOAD_LEN)
  ) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (sym_data_i),
    .cap_en_i  (cap_en),
    .cap_idx_i (cap_idx),
    .accept_i  (accept),
    .valid_o   (decode_valid_o),
    .fields_o  (fields_o)
  );

endmodule

// File: rtl/fixlen_pkt_decoder_chk.sv
module fixlen_pkt_decoder_chk #(
  parameter int FIELDS_W = 48
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sym_valid_i,
  input logic [1:0]          sym_kind_i,
  input logic                chk_done_i,
  input logic                chk_err_i,
  input logic                decode_valid_o,
  input logic [FIELDS_W-1:0] fields_o
);

  logic saw_eop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) saw_eop_q <= 1'b0;
    else if (sym_valid_i && sym_kind_i == 2'b11) saw_eop_q <= 1'b1;
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_valid_o |=> !decode_valid_o);

  // R3
  verdict_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_valid_o |-> $past(chk_done_i && !chk_err_i));

  // R9
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decode_valid_o |-> $stable(fields_o));

  // R10
  eop_before_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_valid_o |-> saw_eop_q);

endmodule

bind fixlen_pkt_decoder fixlen_pkt_decoder_chk #(
  .FIELDS_W (DATA_W * PAYLOAD_LEN)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sym_valid_i    (sym_valid_i),
  .sym_kind_i     (sym_kind_i),
  .chk_done_i     (chk_done_i),
  .chk_err_i      (chk_err_i),
  .decode_valid_o (decode_valid_o),
  .fields_o       (fields_o)
);

// File: tb/fixlen_pkt_decoder_test.sv
module fixlen_pkt_decoder_test;

  localparam int LEN = 6;
  localparam int FW  = 8 * LEN;
  localparam logic [1:0] K_IDLE = 2'b00, K_SOP = 2'b01, K_DATA = 2'b10, K_EOP = 2'b11;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sym_valid_i = 1'b0;
  logic [1:0]    sym_kind_i = K_IDLE;
  logic [7:0]    sym_data_i = '0;
  logic          chk_done_i = 1'b0;
  logic          chk_err_i = 1'b0;
  logic          decode_valid_o;
  logic [FW-1:0] fields_o;

  int            n_chk = 0;
  int            n_bad = 0;
  bit            done_flag = 1'b0;
  logic [FW-1:0] exp_fields = '0;

  always #5 clk_i = ~clk_i;

  fixlen_pkt_decoder uut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sym_valid_i    (sym_valid_i),
    .sym_kind_i     (sym_kind_i),
    .sym_data_i     (sym_data_i),
    .chk_done_i     (chk_done_i),
    .chk_err_i      (chk_err_i),
    .decode_valid_o (decode_valid_o),
    .fields_o       (fields_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // drive one cycle, then sample both outputs just after the edge
  task automatic step(input logic v, input logic [1:0] k, input logic [7:0] d,
                      input logic dn, input logic e, input logic exp_v, input string req);
    @(negedge clk_i);
    sym_valid_i = v; sym_kind_i = k; sym_data_i = d;
    chk_done_i = dn; chk_err_i = e;
    @(posedge clk_i);
    #2;
    check(decode_valid_o === exp_v, req, "valid", FW'(decode_valid_o), FW'(exp_v));
    check(fields_o === exp_fields, req, "fields", fields_o, exp_fields);
  endtask

  function automatic logic [FW-1:0] pack(input logic [7:0] b [LEN]);
    logic [FW-1:0] r = '0;
    for (int i = 0; i < LEN; i++) r[i*8 +: 8] = b[i];
    return r;
  endfunction

  function automatic bit expect_accept(input int mode, input bit err);
    return (mode == 0 || mode == 2) && !err;
  endfunction

  function automatic string mode_req(input int mode, input bit err);
    if (err && expect_accept(mode, 1'b0)) return "R3";
    case (mode)
      0: return "R2";
      1: return "R7";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic maybe_stall(input bit en);
    if (en && ($urandom % 4 == 0))
      step(1'b0, 2'($urandom), 8'($urandom), 1'b0, 1'b0, 1'b0, "R8");
  endtask

  function automatic logic [7:0] first_byte(input bit good);
    logic [3:0] t = 4'hA;
    if (!good) begin
      t = 4'($urandom);
      if (t == 4'hA) t = 4'h5;
    end
    return {t, 4'($urandom)};
  endfunction

  // modes: 0 good, 1 wrong type, 2 restart by start symbol, 3 bad end slot,
  // 4 idle inside payload, 5 end inside payload
  task automatic send_pkt(input int mode, input bit err, input bit stalls);
    logic [7:0] b [LEN];
    int         pos;
    string      req;
    bit         acc;
    req = mode_req(mode, err);
    acc = expect_accept(mode, err);
    for (int i = 0; i < LEN; i++) b[i] = 8'($urandom);
    b[0] = first_byte(mode != 1);
    pos  = $urandom % LEN;
    step(1'b1, K_SOP, 8'($urandom), 1'b0, 1'b0, 1'b0, req);
    if (mode == 2) begin
      int pre = 1 + ($urandom % LEN);
      for (int i = 0; i < pre; i++)
        step(1'b1, K_DATA, (i == 0) ? first_byte(1'b1) : 8'($urandom), 1'b0, 1'b0, 1'b0, "R4");
      step(1'b1, K_SOP, 8'($urandom), 1'b0, 1'b0, 1'b0, "R4");
    end
    for (int i = 0; i < LEN; i++) begin
      maybe_stall(stalls);
      if ((mode == 4 || mode == 5) && i == pos)
        step(1'b1, (mode == 4) ? K_IDLE : K_EOP, 8'($urandom), 1'b0, 1'b0, 1'b0, "R6");
      step(1'b1, K_DATA, b[i], 1'b0, 1'b0, 1'b0, req);
    end
    maybe_stall(stalls);
    step(1'b1, (mode == 3) ? (($urandom % 2) ? K_DATA : K_IDLE) : K_EOP,
         8'($urandom), 1'b0, 1'b0, 1'b0, req);
    for (int g = 0; g < int'($urandom % 3); g++)
      step(1'b1, K_IDLE, 8'($urandom), 1'b0, 1'b0, 1'b0, req);
    if (acc) exp_fields = pack(b);
    step(1'b0, K_IDLE, 8'h00, 1'b1, err, acc, req);
    step(1'b0, K_IDLE, 8'h00, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  // directed: good packet up to its end symbol, no verdict yet
  task automatic send_framed(output logic [FW-1:0] f, input string req);
    logic [7:0] b [LEN];
    for (int i = 0; i < LEN; i++) b[i] = 8'($urandom);
    b[0] = first_byte(1'b1);
    f = pack(b);
    for (int i = 0; i < LEN; i++) step(1'b1, K_DATA, b[i], 1'b0, 1'b0, 1'b0, req);
    step(1'b1, K_EOP, 8'h00, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog", "timeout", '0, '1);
    finish_run();
  end

  initial begin
    logic [FW-1:0] f1, f2;
    void'($urandom(32'd2718));
    // R1: outputs during and after reset
    repeat (3) @(posedge clk_i);
    #2;
    check(decode_valid_o === 1'b0, "R1", "valid in reset", FW'(decode_valid_o), '0);
    check(fields_o === '0, "R1", "fields in reset", fields_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, K_IDLE, 8'h00, 1'b0, 1'b0, 1'b0, "R1");

    // R10: stray verdicts, with and without a lone end symbol
    step(1'b0, K_IDLE, 8'h00, 1'b1, 1'b0, 1'b0, "R10");
    step(1'b1, K_EOP, 8'h00, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, K_IDLE, 8'h00, 1'b1, 1'b0, 1'b0, "R10");
    step(1'b1, K_DATA, 8'hA5, 1'b1, 1'b0, 1'b0, "R10");

    // R8: start symbol with valid low is ignored, then a good packet
    step(1'b0, K_SOP, 8'h00, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, K_DATA, 8'hA1, 1'b0, 1'b0, 1'b0, "R8");
    send_pkt(0, 1'b0, 1'b0);

    // R11: start while waiting drops packet; a verdict after that is ignored
    step(1'b1, K_SOP, 8'h00, 1'b0, 1'b0, 1'b0, "R11");
    send_framed(f1, "R11");
    step(1'b1, K_SOP, 8'h00, 1'b0, 1'b0, 1'b0, "R11");
    step(1'b0, K_IDLE, 8'h00, 1'b1, 1'b0, 1'b0, "R11");
    send_framed(f2, "R11");
    exp_fields = f2;
    step(1'b0, K_IDLE, 8'h00, 1'b1, 1'b0, 1'b1, "R11");

    // R11: verdict and new start in the same cycle
    step(1'b1, K_SOP, 8'h00, 1'b0, 1'b0, 1'b0, "R11");
    send_framed(f1, "R11");
    exp_fields = f1;
    step(1'b1, K_SOP, 8'h00, 1'b1, 1'b0, 1'b1, "R11");
    send_framed(f2, "R11");
    exp_fields = f2;
    step(1'b0, K_IDLE, 8'h00, 1'b1, 1'b0, 1'b1, "R11");
    step(1'b0, K_IDLE, 8'h00, 1'b0, 1'b0, 1'b0, "R9");

    // directed per-mode corners, then random mix
    for (int m = 0; m < 6; m++) send_pkt(m, 1'b0, 1'b0);
    send_pkt(0, 1'b1, 1'b0);
    for (int n = 0; n < 400; n++) begin
      int  m = $urandom % 6;
      bit  e = ($urandom % 4 == 0);
      send_pkt(m, e, 1'b1);
      if ($urandom % 3 == 0)
        step(1'b1, ($urandom % 2) ? K_DATA : K_EOP, 8'($urandom), $urandom % 2, 1'b0, 1'b0, "R10");
    end
    finish_run();
  end

endmodule